// File: doc/BRIEF.md
# Age-Tagged Random-Slot Instruction Window

This block is the instruction window of a small out-of-order core. It has eight slots. A dispatched instruction goes into whichever slot is empty, not behind a tail pointer. Program order is carried only by an 8-bit age tag. The tag comes from a free-running dispatch counter and is stored with each entry. No head or tail pointer exists anywhere. Every "oldest" decision compares tags modulo 256. This is safe because no more than eight tags are ever live at once.

The decode, issue and writeback stages each address the window by slot index:

- **Decode selector:** points at the oldest entry that has not yet been decoded.
- **Issue selector:** points at the oldest decoded entry that has not yet been issued.
- **Writeback:** a completion notice names the slot directly.

Retirement always looks at the oldest live entry. It retires that entry in the same cycle once the entry has completed. A branch-mispredict flush carries the branch's tag. It kills every live entry younger than that tag, wherever the entry sits, and restarts the dispatch counter just after the branch.

Top module: `seqslot_window`

## Requirements
- R1: After a synchronous active-low reset, all slots are empty and `full_o` is 0. `disp_slot_o` and `disp_seq_o` are 0, and `dec_valid_o`, `iss_valid_o`, `retire_valid_o` and `freed_mask_o` are all 0.
- R2: A dispatch is accepted when `disp_valid_i` is 1, `full_o` is 0 and `flush_i` is 0. It writes the lowest-numbered empty slot, which is shown on `disp_slot_o`. It stamps the entry with the tag shown on `disp_seq_o`, and the counter then steps by one.
- R3: `full_o` is 1 exactly when all eight slots hold live entries. A dispatch while full is dropped and consumes no tag.
- R4: Emptiness is judged at the start of the cycle. A slot freed by retirement or flush can be allocated from the next cycle on, not in the cycle that frees it.
- R5: Tag A is older than tag B when bit 7 of (A − B mod 256) is 1. When the oldest live entry has completed and no flush is present, `retire_valid_o` is 1 in that cycle. In that case `retire_slot_o`, `retire_seq_o` and `retire_payload_o` describe that entry, and the slot is emptied at the clock edge. A younger completed entry never retires ahead of an older incomplete one.
- R6: A completion (`done_valid_i`, `done_slot_i`) marks the named live entry as finished. A completion aimed at an empty slot has no effect.
- R7: A flush with `flush_seq_i` empties every live entry whose tag T satisfies 1 ≤ (T − `flush_seq_i` mod 256) ≤ 127, and reports them on `freed_mask_o` (bit n = slot n). In that cycle, dispatch and retirement are suppressed. The next dispatch tag becomes `flush_seq_i` + 1.
- R8: `dec_valid_o`/`dec_slot_o` name the oldest live entry that has not been decoded. `dec_ack_i` marks that entry decoded.
- R9: `iss_valid_o`/`iss_slot_o`/`iss_seq_o` name the oldest entry that is decoded but not yet issued. `iss_ack_i` marks that entry issued.
- R10: Without a flush, `freed_mask_o` is the one-hot of `retire_slot_o` when retiring, and 0 otherwise.
- R11: Ordering, retirement and flushing stay correct when tags wrap from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid_i | input | 1 | Dispatch request |
| disp_payload_i | input | 16 | Instruction payload to store |
| full_o | output | 1 | No empty slot this cycle |
| disp_slot_o | output | 3 | Slot a dispatch would take |
| disp_seq_o | output | 8 | Tag a dispatch would receive |
| dec_ack_i | input | 1 | Decode consumed the selected entry |
| dec_valid_o | output | 1 | A not-yet-decoded entry exists |
| dec_slot_o | output | 3 | Oldest not-yet-decoded slot |
| iss_ack_i | input | 1 | Issue consumed the selected entry |
| iss_valid_o | output | 1 | A ready, not-yet-issued entry exists |
| iss_slot_o | output | 3 | Oldest ready slot |
| iss_seq_o | output | 8 | Tag of that slot |
| done_valid_i | input | 1 | Completion notice |
| done_slot_i | input | 3 | Slot that completed |
| flush_i | input | 1 | Mispredict flush |
| flush_seq_i | input | 8 | Tag of the mispredicted branch |
| retire_valid_o | output | 1 | Oldest entry retires this cycle |
| retire_slot_o | output | 3 | Retiring slot |
| retire_seq_o | output | 8 | Retiring tag |
| retire_payload_o | output | 16 | Retiring payload |
| freed_mask_o | output | 8 | Slots emptied at this edge |

## Verification
The hardest case to reach is a flush that hits live entries scattered over non-adjacent slots while their tags straddle the 255-to-0 wrap. Only then do position order, tag order and raw numeric order all disagree. The stimulus runs several thousand cycles of random traffic. Completions land out of order, so slots are retired and reused in a scrambled pattern. Flushes take the tag of a randomly chosen live entry. More than 256 dispatches occur, so the live tags cross the wrap many times while the behavioural model is compared with the ports every cycle.

// File: rtl/seqslot_pkg.sv
// Shared types and default sizes for the age-tagged instruction window.
// Assumes: consumers take their widths from the parameters below.
package seqslot_pkg;

    localparam int SLOTS_DEF = 8;
    localparam int SEQ_W_DEF = 8;
    localparam int PAY_W_DEF = 16;

    // Per-slot lifecycle flags.
    typedef struct packed {
        logic valid;
        logic decoded;
        logic issued;
        logic done;
    } slot_flags_t;

endpackage

// File: rtl/seqslot_free_pick.sv
// Lowest-index empty-slot finder.
// Assumes: busy_i bit n is 1 when slot n holds a live entry; idx_o is 0
// when nothing is free.
module seqslot_free_pick #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     busy_i,
    output logic             any_free_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan from the top so the lowest empty slot is written last and wins.
    always_comb begin
        any_free_o = 1'b0;
        idx_o      = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy_i[i]) begin
                any_free_o = 1'b1;
                idx_o      = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/seqslot_age_pick.sv
// Oldest-entry selector over a candidate mask, by modulo tag comparison.
// Assumes: candidate tags are distinct and span fewer than half the tag
// space, so each pairwise comparison is unambiguous.
module seqslot_age_pick #(
    parameter int N     = 8,
    parameter int SEQ_W = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]            mask_i,
    input  logic [N-1:0][SEQ_W-1:0] seq_i,
    output logic                    found_o,
    output logic [IDX_W-1:0]        idx_o
);

    function automatic logic tag_older(input logic [SEQ_W-1:0] a,
                                       input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] d;
        d = a - b;
        return d[SEQ_W-1];
    endfunction

    logic [N-1:0] winner;

    // Each candidate wins if it beats every other candidate pairwise.
    for (genvar i = 0; i < N; i++) begin : g_row
        logic [N-1:0] beats;
        for (genvar j = 0; j < N; j++) begin : g_col
            if (i == j) begin : g_self
                assign beats[j] = 1'b1;
            end else begin : g_other
                assign beats[j] = !mask_i[j] || tag_older(seq_i[i], seq_i[j]);
            end
        end
        assign winner[i] = mask_i[i] && (&beats);
    end

    // Encode the (one-hot) winner into a slot index.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (winner[i]) idx_o = idx_o | IDX_W'(i);
        end
    end

    assign found_o = |mask_i;

endmodule

// File: rtl/seqslot_window.sv
// Eight-slot instruction window with random-slot allocation and age tags.
// Dispatch takes the lowest empty slot; age lives in a per-entry tag from a
// free-running counter. Decode, issue and retire selectors jump straight to
// the oldest qualifying slot; a flush kills every entry younger than the
// branch tag. Assumes: at most NUM_SLOTS live tags (far below half the tag
// space), flush tags name a live entry, synchronous active-low reset.
module seqslot_window
    import seqslot_pkg::*;
#(
    parameter int NUM_SLOTS = SLOTS_DEF,
    parameter int SEQ_W     = SEQ_W_DEF,
    parameter int PAY_W     = PAY_W_DEF,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 disp_valid_i,
    input  logic [PAY_W-1:0]     disp_payload_i,
    output logic                 full_o,
    output logic [IDX_W-1:0]     disp_slot_o,
    output logic [SEQ_W-1:0]     disp_seq_o,
    input  logic                 dec_ack_i,
    output logic                 dec_valid_o,
    output logic [IDX_W-1:0]     dec_slot_o,
    input  logic                 iss_ack_i,
    output logic                 iss_valid_o,
    output logic [IDX_W-1:0]     iss_slot_o,
    output logic [SEQ_W-1:0]     iss_seq_o,
    input  logic                 done_valid_i,
    input  logic [IDX_W-1:0]     done_slot_i,
    input  logic                 flush_i,
    input  logic [SEQ_W-1:0]     flush_seq_i,
    output logic                 retire_valid_o,
    output logic [IDX_W-1:0]     retire_slot_o,
    output logic [SEQ_W-1:0]     retire_seq_o,
    output logic [PAY_W-1:0]     retire_payload_o,
    output logic [NUM_SLOTS-1:0] freed_mask_o
);

    // True when tag a is strictly younger than tag b (modulo compare).
    function automatic logic tag_younger(input logic [SEQ_W-1:0] a,
                                         input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] d;
        d = a - b;
        return (d != '0) && !d[SEQ_W-1];
    endfunction

    slot_flags_t [NUM_SLOTS-1:0]            flg_v;
    logic        [NUM_SLOTS-1:0][SEQ_W-1:0] seq_v;
    logic        [NUM_SLOTS-1:0][PAY_W-1:0] pay_v;

    logic [NUM_SLOTS-1:0] valid_m, undec_m, ready_m, kill_m;
    logic [SEQ_W-1:0]     next_seq_q;
    logic                 any_free;
    logic [IDX_W-1:0]     free_idx;
    logic                 ret_any;
    logic [IDX_W-1:0]     ret_idx;
    logic                 disp_fire, retire_fire;

    // Per-slot qualifier masks for the selectors and the flush.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_mask
        assign valid_m[s] = flg_v[s].valid;
        assign undec_m[s] = flg_v[s].valid && !flg_v[s].decoded;
        assign ready_m[s] = flg_v[s].valid && flg_v[s].decoded && !flg_v[s].issued;
        assign kill_m[s]  = flg_v[s].valid && tag_younger(seq_v[s], flush_seq_i);
    end

    seqslot_free_pick #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_free (
        .busy_i     (valid_m),
        .any_free_o (any_free),
        .idx_o      (free_idx)
    );

    seqslot_age_pick #(.N(NUM_SLOTS), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_dec_pick (
        .mask_i  (undec_m),
        .seq_i   (seq_v),
        .found_o (dec_valid_o),
        .idx_o   (dec_slot_o)
    );

    seqslot_age_pick #(.N(NUM_SLOTS), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_iss_pick (
        .mask_i  (ready_m),
        .seq_i   (seq_v),
        .found_o (iss_valid_o),
        .idx_o   (iss_slot_o)
    );

    seqslot_age_pick #(.N(NUM_SLOTS), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_ret_pick (
        .mask_i  (valid_m),
        .seq_i   (seq_v),
        .found_o (ret_any),
        .idx_o   (ret_idx)
    );

    assign full_o      = !any_free;
    assign disp_slot_o = free_idx;
    assign disp_seq_o  = next_seq_q;
    assign iss_seq_o   = seq_v[iss_slot_o];
    assign disp_fire   = disp_valid_i && any_free && !flush_i;
    assign retire_fire = ret_any && flg_v[ret_idx].done && !flush_i;

    assign retire_valid_o   = retire_fire;
    assign retire_slot_o    = ret_idx;
    assign retire_seq_o     = seq_v[ret_idx];
    assign retire_payload_o = pay_v[ret_idx];

    // Slots emptied at this edge: the flush victims, or the retiring slot.
    always_comb begin
        freed_mask_o = '0;
        if (flush_i)          freed_mask_o = kill_m;
        else if (retire_fire) freed_mask_o[ret_idx] = 1'b1;
    end

    // Dispatch tag counter: steps on accept, restarts after a flushed branch.
    always_ff @(posedge clk) begin
        if (!rst_n)         next_seq_q <= '0;
        else if (flush_i)   next_seq_q <= flush_seq_i + 1'b1;
        else if (disp_fire) next_seq_q <= next_seq_q + 1'b1;
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        slot_flags_t      flg_r;
        logic [SEQ_W-1:0] seq_r;
        logic [PAY_W-1:0] pay_r;

        // Slot lifecycle: kill, retire, allocate, else stage marks.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flg_r <= '0;
            end else if (flush_i && kill_m[s]) begin
                flg_r <= '0;
            end else if (retire_fire && ret_idx == IDX_W'(s)) begin
                flg_r <= '0;
            end else if (disp_fire && free_idx == IDX_W'(s)) begin
                flg_r <= '{valid: 1'b1, decoded: 1'b0, issued: 1'b0, done: 1'b0};
            end else begin
                if (done_valid_i && done_slot_i == IDX_W'(s) && flg_r.valid)
                    flg_r.done <= 1'b1;
                if (dec_ack_i && dec_valid_o && dec_slot_o == IDX_W'(s))
                    flg_r.decoded <= 1'b1;
                if (iss_ack_i && iss_valid_o && iss_slot_o == IDX_W'(s))
                    flg_r.issued <= 1'b1;
            end
        end

        // Tag and payload capture on allocation.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seq_r <= '0;
                pay_r <= '0;
            end else if (disp_fire && free_idx == IDX_W'(s)) begin
                seq_r <= next_seq_q;
                pay_r <= disp_payload_i;
            end
        end

        assign flg_v[s] = flg_r;
        assign seq_v[s] = seq_r;
        assign pay_v[s] = pay_r;
    end

    // R2: an accepted dispatch appears live in its slot with the offered tag.
    p_alloc_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        disp_fire |=> flg_v[$past(free_idx)].valid &&
                      seq_v[$past(free_idx)] == $past(disp_seq_o));

    // R2: the offered tag steps by exactly one after an accepted dispatch.
    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        disp_fire && !flush_i |=> disp_seq_o == SEQ_W'($past(disp_seq_o) + 1'b1));

    // R3: a full window stays full when nothing leaves it.
    p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full_o && !retire_valid_o && !flush_i |=> full_o);

    // R5: back-to-back retirements go strictly forward in age (also across wrap, R11).
    p_retire_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid_o && $past(retire_valid_o) |->
            tag_younger(retire_seq_o, $past(retire_seq_o)));

    // R4: a retired slot is still empty one cycle later.
    p_retire_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid_o |=> !flg_v[$past(retire_slot_o)].valid);

    // R7: no flush victim survives the flush edge.
    p_flush_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (valid_m & $past(kill_m)) == '0);

    // R10: without a flush at most one slot is freed per cycle.
    p_freed_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_i |-> $onehot0(freed_mask_o));

endmodule

// File: tb/seqslot_window_bench.sv
`timescale 1ns/1ps
// Bench: behavioural program-order queue model compared with the ports every cycle.
module seqslot_window_bench;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid_i = 1'b0;
    logic [15:0] disp_payload_i = '0;
    logic        full_o;
    logic [2:0]  disp_slot_o;
    logic [7:0]  disp_seq_o;
    logic        dec_ack_i = 1'b0;
    logic        dec_valid_o;
    logic [2:0]  dec_slot_o;
    logic        iss_ack_i = 1'b0;
    logic        iss_valid_o;
    logic [2:0]  iss_slot_o;
    logic [7:0]  iss_seq_o;
    logic        done_valid_i = 1'b0;
    logic [2:0]  done_slot_i = '0;
    logic        flush_i = 1'b0;
    logic [7:0]  flush_seq_i = '0;
    logic        retire_valid_o;
    logic [2:0]  retire_slot_o;
    logic [7:0]  retire_seq_o;
    logic [15:0] retire_payload_o;
    logic [7:0]  freed_mask_o;

    seqslot_window u_seqslot_window (.*);

    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;

    // Reference model: slots listed in program order, plus per-slot data.
    int         ord[$];
    bit [7:0]   mseq[N];
    bit [15:0]  mpay[N];
    bit         mdec[N], miss[N], mdone[N];
    bit [7:0]   nseq = 0;

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic bit live(int s);
        foreach (ord[k]) if (ord[k] == s) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int low_free();
        for (int s = 0; s < N; s++) if (!live(s)) return s;
        return 0;
    endfunction

    function automatic int dec_pick();
        foreach (ord[k]) if (!mdec[ord[k]]) return ord[k];
        return -1;
    endfunction

    function automatic int iss_pick();
        foreach (ord[k]) if (mdec[ord[k]] && !miss[ord[k]]) return ord[k];
        return -1;
    endfunction

    function automatic int kill_pos();
        foreach (ord[k]) if (mseq[ord[k]] == flush_seq_i) return k;
        return ord.size() - 1;
    endfunction

    // Compare every port against the model for the current inputs.
    task automatic compare();
        int dp, ip, kp;
        bit rv;
        bit [7:0] fm;
        dp = dec_pick();
        ip = iss_pick();
        rv = !flush_i && ord.size() > 0 && mdone[ord[0]];
        fm = '0;
        if (flush_i) begin
            kp = kill_pos();
            for (int k = kp + 1; k < ord.size(); k++) fm[ord[k]] = 1'b1;
        end else if (rv) fm[ord[0]] = 1'b1;
        check("R3 full_o", int'(full_o), int'(ord.size() == N));
        if (ord.size() < N) check("R2 R4 disp_slot_o", int'(disp_slot_o), low_free());
        check("R2 R11 disp_seq_o", int'(disp_seq_o), int'(nseq));
        check("R8 dec_valid_o", int'(dec_valid_o), int'(dp >= 0));
        if (dp >= 0) check("R8 dec_slot_o", int'(dec_slot_o), dp);
        check("R9 iss_valid_o", int'(iss_valid_o), int'(ip >= 0));
        if (ip >= 0) begin
            check("R9 iss_slot_o", int'(iss_slot_o), ip);
            check("R9 iss_seq_o", int'(iss_seq_o), int'(mseq[ip]));
        end
        check("R5 R6 retire_valid_o", int'(retire_valid_o), int'(rv));
        if (rv) begin
            check("R5 retire_slot_o", int'(retire_slot_o), ord[0]);
            check("R5 R11 retire_seq_o", int'(retire_seq_o), int'(mseq[ord[0]]));
            check("R5 retire_payload_o", int'(retire_payload_o), int'(mpay[ord[0]]));
        end
        check("R7 R10 freed_mask_o", int'(freed_mask_o), int'(fm));
    endtask

    // Advance the model across one clock edge using the current inputs.
    task automatic model_edge();
        int dp, ip, lf, kp;
        bit was_full, rv, dn;
        dp = dec_pick();
        ip = iss_pick();
        lf = low_free();
        was_full = (ord.size() == N);
        rv = ord.size() > 0 && mdone[ord[0]];
        dn = done_valid_i && live(int'(done_slot_i));
        if (dn) mdone[done_slot_i] = 1'b1;
        if (dec_ack_i && dp >= 0) mdec[dp] = 1'b1;
        if (iss_ack_i && ip >= 0) miss[ip] = 1'b1;
        if (flush_i) begin
            kp = kill_pos();
            while (ord.size() > kp + 1) void'(ord.pop_back());
            nseq = flush_seq_i + 8'd1;
        end else begin
            if (rv) void'(ord.pop_front());
            if (disp_valid_i && !was_full) begin
                mseq[lf] = nseq;
                mpay[lf] = disp_payload_i;
                mdec[lf] = 1'b0;
                miss[lf] = 1'b0;
                mdone[lf] = 1'b0;
                ord.push_back(lf);
                nseq = nseq + 8'd1;
            end
        end
    endtask

    task automatic idle_inputs();
        disp_valid_i = 1'b0;
        dec_ack_i    = 1'b0;
        iss_ack_i    = 1'b0;
        done_valid_i = 1'b0;
        flush_i      = 1'b0;
    endtask

    // One cycle: inputs already set at the falling edge.
    task automatic tick();
        #1;
        compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic dispatch(bit [15:0] p);
        disp_valid_i = 1'b1;
        disp_payload_i = p;
    endtask

    task automatic complete(int s);
        done_valid_i = 1'b1;
        done_slot_i = 3'(s);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state at the ports.
        check("R1 full_o", int'(full_o), 0);
        check("R1 disp_slot_o", int'(disp_slot_o), 0);
        check("R1 disp_seq_o", int'(disp_seq_o), 0);
        check("R1 dec_valid_o", int'(dec_valid_o), 0);
        check("R1 iss_valid_o", int'(iss_valid_o), 0);
        check("R1 retire_valid_o", int'(retire_valid_o), 0);
        check("R1 freed_mask_o", int'(freed_mask_o), 0);
        @(negedge clk);

        // R2/R3: fill all eight slots, then one dispatch while full.
        for (int i = 0; i < 9; i++) begin
            dispatch(16'h1000 + 16'(i));
            tick();
        end
        // R8/R9: walk decode and issue forward.
        dec_ack_i = 1'b1; tick();
        dec_ack_i = 1'b1; tick();
        iss_ack_i = 1'b1; tick();
        // R5: a younger completion cannot retire ahead of the oldest.
        complete(3); tick();
        tick();
        // R4: retire slot 0 and try to refill it in the same cycle.
        complete(0); dispatch(16'hAAAA); tick();
        dispatch(16'hBBBB); tick();
        // R6: completion to slot 5 while live; then flush behind slot 2.
        complete(5); tick();
        flush_i = 1'b1; flush_seq_i = mseq[2]; dispatch(16'hCCCC); tick();
        // R6: completion to a now-empty slot is ignored.
        complete(5); tick();
        tick();
        dispatch(16'hDDDD); tick();
        dispatch(16'hEEEE); tick();

        // Random traffic: scattered reuse, out-of-order completion, wrap (R11).
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(99) < 65) dispatch(16'($urandom));
            if ($urandom_range(99) < 60) dec_ack_i = 1'b1;
            if ($urandom_range(99) < 55) iss_ack_i = 1'b1;
            if (ord.size() > 0 && $urandom_range(99) < 60)
                complete(ord[$urandom_range(ord.size() - 1)]);
            else if ($urandom_range(99) < 10)
                complete(int'($urandom_range(N - 1)));
            if (ord.size() > 0 && $urandom_range(99) < 4) begin
                flush_i = 1'b1;
                flush_seq_i = mseq[ord[$urandom_range(ord.size() - 1)]];
            end
            tick();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule